// File: doc/BRIEF.md
# Framed Four-Bit Pattern Detector

This block watches a serial bit stream and cuts it into back-to-back frames of four accepted bits. A frame never shares bits with its neighbours. When the fourth bit of a frame is presented, the output `match` is raised if the whole frame equals `0110` or `1010`. The first bit accepted in a frame is the leftmost pattern bit. After every fourth bit the machine goes back to its start state, whether the frame matched or not. A bit is accepted only on a clock edge where `bit_valid` is high, so the source may leave gaps of any length between bits.

The controller is a reduced machine with seven states. `ST_START` waits for the first bit. `ST_ONE_Z` and `ST_ONE_O` hold a first bit of 0 or 1. `ST_GOOD2` holds the merged two-bit prefixes 01 and 10, which both still need 10 to match. `ST_BAD2` holds any other two-bit prefix. `ST_GOOD3` holds the live three-bit prefixes 011 and 101. `ST_BAD3` holds any other three-bit prefix.

Transitions on an accepted bit are:
- START: on 0 to ONE_Z, on 1 to ONE_O.
- ONE_Z: on 1 to GOOD2, on 0 to BAD2.
- ONE_O: on 0 to GOOD2, on 1 to BAD2.
- GOOD2: on 1 to GOOD3, on 0 to BAD3.
- BAD2: on either bit to BAD3.
- GOOD3: on either bit to START.
- BAD3: on either bit to START.

`match` is a Mealy output. It is high only while the machine is in GOOD3 and an accepted 0 is being presented.

Top module: `quad_frame_matcher`

## Requirements
- R1: While `rst` is high on a clock edge, the machine goes to the start state. After reset is released, `match` is low and the next accepted bit is the first bit of a new frame.
- R2: A bit is accepted only when `bit_valid` is high. While `bit_valid` is low, the state holds and `match` stays low, whatever the value on `din`.
- R3: A frame of 0110 raises `match` during the cycle in which its fourth bit is presented with `bit_valid` high.
- R4: A frame of 1010 raises `match` in the same way.
- R5: For each of the other fourteen four-bit frames, `match` stays low for the whole frame.
- R6: Frames do not overlap. After its fourth accepted bit, every frame returns to the start state, so a target pattern that spans two frames is never reported.
- R7: Bit order: the first accepted bit of a frame is compared with the leftmost pattern bit. For example, 0110 is delivered as 0, 1, 1, 0.
- R8: A reset in the middle of a frame discards the partial frame. Bits that follow are framed afresh from the reset.
- R9: `match` is never high except on the fourth accepted bit of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Qualifies `din` on this edge |
| din | input | 1 | Serial data bit |
| match | output | 1 | Mealy flag: the frame ending now matched |

## Verification
The bound checker keeps its own count of accepted bits. On every cycle it checks that the machine sits in the start state at each frame boundary, and that `match` appears only on a fourth accepted bit. It also checks that idle cycles freeze the state and keep `match` low, and that a failed prefix never reports a match. Some behaviour cannot be shown by these per-cycle checks and is left to the bench scenarios. These are the exact pattern contents and bit order, and the fact that straddling patterns go unreported. The bench sweeps every pair of back-to-back frames to show them. It also shows realignment after a reset in the middle of a frame.

// File: rtl/qfm_pkg.sv
package qfm_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_START = 3'd0,
        ST_ONE_Z = 3'd1,
        ST_ONE_O = 3'd2,
        ST_GOOD2 = 3'd3,
        ST_BAD2  = 3'd4,
        ST_GOOD3 = 3'd5,
        ST_BAD3  = 3'd6
    } state_t;
endpackage

// File: rtl/qfm_next.sv
module qfm_next
    import qfm_pkg::*;
(
    input  state_t cur,
    input  logic   take,
    input  logic   bit_in,
    output state_t nxt
);
    always_comb begin
        nxt = cur;
        if (take) begin
            unique case (cur)
                ST_START: nxt = bit_in ? ST_ONE_O : ST_ONE_Z;
                ST_ONE_Z: nxt = bit_in ? ST_GOOD2 : ST_BAD2;
                ST_ONE_O: nxt = bit_in ? ST_BAD2  : ST_GOOD2;
                ST_GOOD2: nxt = bit_in ? ST_GOOD3 : ST_BAD3;
                ST_BAD2:  nxt = ST_BAD3;
                ST_GOOD3: nxt = ST_START;
                ST_BAD3:  nxt = ST_START;
                default:  nxt = ST_START;
            endcase
        end
    end
endmodule

// File: rtl/qfm_out.sv
module qfm_out
    import qfm_pkg::*;
(
    input  state_t cur,
    input  logic   take,
    input  logic   bit_in,
    output logic   hit
);
    always_comb begin
        hit = 1'b0;
        unique case (cur)
            ST_GOOD3: hit = take & ~bit_in;
            ST_START, ST_ONE_Z, ST_ONE_O, ST_GOOD2,
            ST_BAD2, ST_BAD3: hit = 1'b0;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/quad_frame_matcher.sv
module quad_frame_matcher
    import qfm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic din,
    output logic match
);
    state_t state;
    state_t state_nx;

    qfm_next u_next (
        .cur    (state),
        .take   (bit_valid),
        .bit_in (din),
        .nxt    (state_nx)
    );

    qfm_out u_out (
        .cur    (state),
        .take   (bit_valid),
        .bit_in (din),
        .hit    (match)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= ST_START;
        else     state <= state_nx;
    end
endmodule

// File: rtl/qfm_checker.sv
module qfm_checker
    import qfm_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   bit_valid,
    input logic   din,
    input logic   match,
    input state_t state
);
    logic [1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)            seen <= 2'd0;
        else if (bit_valid) seen <= seen + 2'd1;
    end

    p_reset_start_r1: assert property (@(posedge clk)
        rst |=> (state == ST_START));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(state));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |-> !match);

    p_bad_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BAD3) |-> !match);

    p_boundary_start_r6: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd0) |-> (state == ST_START));

    p_match_fourth_r9: assert property (@(posedge clk) disable iff (rst)
        match |-> (bit_valid && seen == 2'd3));
endmodule

bind quad_frame_matcher qfm_checker u_qfm_checker (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .din       (din),
    .match     (match),
    .state     (state)
);

// File: tb/quad_frame_matcher_test.sv
module quad_frame_matcher_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic din = 1'b0;
    logic match;
    int   total = 0;
    int   failed = 0;

    quad_frame_matcher uut (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .din       (din),
        .match     (match)
    );

    always #5 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: match=%b expected %b", req, act, exp);
        end
    endtask

    // Drive one cycle after a falling edge, sample mid-cycle, let the edge pass.
    task automatic step(input logic v, input logic b, input logic exp, input string req);
        @(negedge clk);
        bit_valid = v;
        din = b;
        #2;
        check(match, exp, req);
        @(posedge clk);
    endtask

    initial begin
        #1000000;
        failed++;
        total++;
        $display("FAIL watchdog: match=%b expected finish", match);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        bit_valid = 1'b1;
        din = 1'b0;
        #2;
        check(match, 1'b0, "R1 during reset");
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        bit_valid = 1'b0;
        #2;
        check(match, 1'b0, "R1 after reset");

        // R3 R4 R5 R6 R7: every pair of frames, delivered leftmost bit first
        for (int s = 0; s < 256; s++) begin
            logic [7:0] sv;
            sv = s[7:0];
            for (int i = 0; i < 8; i++) begin
                logic [3:0] fr;
                logic       e;
                logic       b;
                fr = (i < 4) ? sv[7:4] : sv[3:0];
                b  = sv[7 - i];
                e  = ((i == 3) || (i == 7)) && ((fr == 4'd6) || (fr == 4'd10));
                if (e && fr == 4'd6)       step(1'b1, b, e, "R3 R7 frame 0110");
                else if (e)                step(1'b1, b, e, "R4 R7 frame 1010");
                else                       step(1'b1, b, e, "R5 R6 no match");
                // R2: a gap with a toggled data bit must not advance or flag
                if (((i + s) % 3) == 0) step(1'b0, ~b, 1'b0, "R2 idle gap");
            end
        end

        // R8: partial frame discarded by reset, then 0110 framed afresh
        step(1'b1, 1'b1, 1'b0, "R8 partial bit");
        step(1'b1, 1'b0, 1'b0, "R8 partial bit");
        @(negedge clk);
        rst = 1'b1;
        bit_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 1'b0, 1'b0, "R8 new frame");
        step(1'b1, 1'b1, 1'b0, "R8 new frame");
        step(1'b1, 1'b1, 1'b0, "R8 new frame");
        step(1'b1, 1'b0, 1'b1, "R8 R9 match after realign");
        // R9: long idle after the match stays quiet
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 1'b0, "R9 quiet");

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule